// File: doc/BRIEF.md
# Link Throughput Statistics Monitor

This block sits beside a streaming transmit link and gathers timing and volume statistics on it. It watches four plain inputs: a connection-up flag, a transmit-FIFO almost-full flag, a local-buffer-empty flag and a write strobe that carries a byte count. It turns them into six 64-bit counters. Time is counted in units of one tick, and one tick is 40 ns. An internal prescaler produces one tick every `TICK_DIV` clock cycles.

Three of the counters cover a measurement window. The window opens at the first write after reset or clear and closes at the most recent write. These counters hold the elapsed window time, the time the local buffer was empty inside the window, and the time almost-full was high inside the window. Time since the last write is held in pending registers and is added to the totals only when the next write arrives. Because of this, the totals always stop exactly at the last write. Two further time counters run whatever the window is doing: connection-up time, and connection-up time with almost-full low. The sixth counter sums the bytes written.

Software reads the counters through a 16-bit register port. Reading the lowest word of a counter takes a 64-bit snapshot of it, and the upper words are then served from that snapshot. A clear strobe zeroes every counter, zeroes the snapshot and re-arms first-write detection. None of the inputs is a data stream: the write strobe is only observed, so the block has no back-pressure and never stalls the link.

Top module: `link_stats_mon`

## Requirements
- R1: After reset every counter reads zero and `rd_valid_o` is low until a read is issued.
- R2: `wr_valid_i` high in a clock cycle is one write of `wr_bytes_i` bytes. The byte counter (index 5) adds `wr_bytes_i` on every write cycle and changes on no other cycle.
- R3: The elapsed-window counter (index 0) equals the number of ticks in the cycles after the first write, up to and including the latest write. Nothing is counted before the first write. One tick occurs every `TICK_DIV` cycles; with `TICK_DIV` = 1 every cycle is a tick.
- R4: The buffer-empty counter (index 1) counts the window ticks on which `buf_empty_i` is high.
- R5: The almost-full counter (index 2) counts the window ticks on which `tx_afull_i` is high.
- R6: The window counters are lazy. Between two writes their readable values do not change, however much time passes.
- R7: The connection-up counter (index 3) counts every tick on which `link_up_i` is high, with or without writes.
- R8: The unblocked counter (index 4) counts every tick on which `link_up_i` is high and `tx_afull_i` is low.
- R9: `rd_addr_i` is {counter index[2:0], word[1:0]}, and word 0 is the least significant 16 bits. `rd_valid_o` and `rd_data_o` appear in the cycle after `rd_en_i`. Indices 6 and 7 read zero.
- R10: A word-0 read captures the whole addressed counter into one shared snapshot. Words 1 to 3 return slices of that snapshot, whatever counter index they carry, and later counter updates do not alter them.
- R11: `clr_i` zeroes all counters and the snapshot and re-arms first-write detection. A write in the clear cycle is ignored: its bytes are not counted and it does not open the window.
- R12: A read issued in the same cycle as a write returns the counter value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear strobe for all statistics |
| link_up_i | input | 1 | Connection-established flag |
| tx_afull_i | input | 1 | Transmit FIFO almost-full flag |
| buf_empty_i | input | 1 | Local buffer empty flag |
| wr_valid_i | input | 1 | Write strobe into the link |
| wr_bytes_i | input | BYTE_W | Byte count of the write |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | ADDR_W | {counter index, word select} |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| rd_data_o | output | WORD_W | Read data word |

## Verification
Two things can happen in the same cycle: a register read and a write that commits pending window time and adds bytes. The bench provokes this by raising `rd_en_i` for word 0 of the byte counter in the same cycle as a write. The returned word must hold the value from before the write, and a second read must show the sum that includes it. The bench also places a write in the clear cycle. It then judges, from later window and byte readings, that this write neither counted nor armed the window.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int NUM_CNT = 6;
  localparam int IDX_W   = 3;
  localparam int WIN_LANES = 3;
  localparam int IX_ELAPSED = 0;
  localparam int IX_EMPTY   = 1;
  localparam int IX_AFULL   = 2;
  localparam int IX_LINKUP  = 3;
  localparam int IX_LINKOK  = 4;
  localparam int IX_BYTES   = 5;
endpackage

// File: rtl/lts_tick_gen.sv
module lts_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else div_q <= div_q + DW'(1);
      end
      assign tick = (div_q == LAST);
      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/lts_window_acc.sv
module lts_window_acc #(
  parameter int CNT_W = 64,
  parameter int LANES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic wr,
  input  logic [LANES-1:0] lvl,
  output logic armed,
  output logic [LANES-1:0][CNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] pend_q [LANES];
  logic [CNT_W-1:0] tot_q  [LANES];
  logic commit;
  assign commit = wr && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else if (clr) armed <= 1'b0;
    else if (wr) armed <= 1'b1;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          pend_q[g] <= '0;
          tot_q[g]  <= '0;
        end else if (commit) begin
          tot_q[g]  <= tot_q[g] + pend_q[g] + CNT_W'(tick && lvl[g]);
          pend_q[g] <= '0;
        end else if (armed && tick && lvl[g]) begin
          pend_q[g] <= pend_q[g] + ONE;
        end
      end
      assign total[g] = tot_q[g];
    end
  endgenerate

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (tot_q[0] == '0 && pend_q[0] == '0));
  // R11
  rearm_only_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(clr));
  // R6
  lazy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !clr) |=> $stable(tot_q[0]) && $stable(tot_q[1]) && $stable(tot_q[2]));
  // R4
  empty_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tot_q[1] <= tot_q[0]);
  // R5
  afull_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tot_q[2] <= tot_q[0]);
endmodule

// File: rtl/lts_level_acc.sv
module lts_level_acc #(
  parameter int CNT_W  = 64,
  parameter int BYTE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic link_up,
  input  logic afull,
  input  logic wr,
  input  logic [BYTE_W-1:0] bytes,
  output logic [CNT_W-1:0] up_time,
  output logic [CNT_W-1:0] ok_time,
  output logic [CNT_W-1:0] byte_sum
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      up_time  <= '0;
      ok_time  <= '0;
      byte_sum <= '0;
    end else begin
      if (tick && link_up) up_time <= up_time + ONE;
      if (tick && link_up && !afull) ok_time <= ok_time + ONE;
      if (wr) byte_sum <= byte_sum + CNT_W'(bytes);
    end
  end

  // R8
  ok_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_time <= up_time);
  // R2
  bytes_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !clr) |=> $stable(byte_sum));
  // R7
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !clr) |=> $stable(up_time));
endmodule

// File: rtl/lts_read_port.sv
module lts_read_port #(
  parameter int CNT_W   = 64,
  parameter int WORD_W  = 16,
  parameter int NUM_CNT = 6,
  parameter int IDX_W   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [$clog2(CNT_W/WORD_W)-1:0] rd_word,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_bus,
  output logic rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int WORDS = CNT_W / WORD_W;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] sel;
  logic [WORD_W-1:0] snap_w [WORDS];
  logic low_rd;

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_slice
      assign snap_w[g] = snap_q[g*WORD_W +: WORD_W];
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (int'(rd_idx) == i) sel = cnt_bus[i];
  end

  assign low_rd = rd_en && (rd_word == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= low_rd ? sel[WORD_W-1:0] : snap_w[rd_word];
      if (clr) snap_q <= '0;
      else if (low_rd) snap_q <= sel;
    end
  end

  // R9
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_rd && !clr) |=> $stable(snap_q));
endmodule

// File: rtl/link_stats_mon.sv
module link_stats_mon #(
  parameter int CNT_W    = 64,
  parameter int WORD_W   = 16,
  parameter int BYTE_W   = 16,
  parameter int TICK_DIV = 4,
  localparam int WSEL_W  = $clog2(CNT_W / WORD_W),
  localparam int ADDR_W  = lts_pkg::IDX_W + WSEL_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic link_up_i,
  input  logic tx_afull_i,
  input  logic buf_empty_i,
  input  logic wr_valid_i,
  input  logic [BYTE_W-1:0] wr_bytes_i,
  input  logic rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);
  import lts_pkg::*;

  logic tick, armed, wr_ok;
  logic [WIN_LANES-1:0][CNT_W-1:0] win_tot;
  logic [CNT_W-1:0] up_time, ok_time, byte_sum;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_bus;

  assign wr_ok = wr_valid_i && !clr_i;

  lts_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  lts_window_acc #(.CNT_W(CNT_W), .LANES(WIN_LANES)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .tick(tick), .wr(wr_ok),
    .lvl({tx_afull_i, buf_empty_i, 1'b1}), .armed(armed), .total(win_tot));

  lts_level_acc #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .tick(tick), .link_up(link_up_i),
    .afull(tx_afull_i), .wr(wr_ok), .bytes(wr_bytes_i),
    .up_time(up_time), .ok_time(ok_time), .byte_sum(byte_sum));

  assign cnt_bus[IX_ELAPSED] = win_tot[0];
  assign cnt_bus[IX_EMPTY]   = win_tot[1];
  assign cnt_bus[IX_AFULL]   = win_tot[2];
  assign cnt_bus[IX_LINKUP]  = up_time;
  assign cnt_bus[IX_LINKOK]  = ok_time;
  assign cnt_bus[IX_BYTES]   = byte_sum;

  lts_read_port #(.CNT_W(CNT_W), .WORD_W(WORD_W), .NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .rd_en(rd_en_i),
    .rd_idx(rd_addr_i[ADDR_W-1 -: IDX_W]), .rd_word(rd_addr_i[WSEL_W-1:0]),
    .cnt_bus(cnt_bus), .rd_valid(rd_valid_o), .rd_data(rd_data_o));

  // R11
  clear_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !armed && byte_sum == '0);
endmodule

// File: tb/link_stats_mon_test.sv
module link_stats_mon_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, clr_i = 1'b0;
  logic link_up_i = 1'b0, tx_afull_i = 1'b0, buf_empty_i = 1'b0;
  logic wr_valid_i = 1'b0, rd_en_i = 1'b0;
  logic [15:0] wr_bytes_i = '0;
  logic [4:0] rd_addr_i = '0;
  logic rd_valid_o;
  logic [15:0] rd_data_o;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  link_stats_mon #(.TICK_DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .link_up_i(link_up_i),
    .tx_afull_i(tx_afull_i), .buf_empty_i(buf_empty_i), .wr_valid_i(wr_valid_i),
    .wr_bytes_i(wr_bytes_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd_word(input int idx, input int w, output logic [15:0] d);
    rd_en_i = 1'b1; rd_addr_i = {3'(idx), 2'(w)};
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
    check("R9 rd_valid", longint'(rd_valid_o), 1);
  endtask

  task automatic rd64(input int idx, output longint v);
    logic [15:0] d;
    v = 0;
    for (int w = 0; w < 4; w++) begin
      rd_word(idx, w, d);
      v = v | (longint'(d) << (16*w));
    end
  endtask

  task automatic do_write(input logic [15:0] b, output int at);
    wr_valid_i = 1'b1; wr_bytes_i = b; at = cyc;
    @(negedge clk);
    wr_valid_i = 1'b0; wr_bytes_i = '0;
  endtask

  task automatic do_clear();
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic t_reset();
    longint v;
    check("R1 rd_valid idle", longint'(rd_valid_o), 0);
    for (int i = 0; i < 6; i++) begin
      rd64(i, v);
      check("R1 counter zero", v, 0);
    end
  endtask

  task automatic t_window();
    int w1, w2, w3;
    longint v;
    do_clear();
    repeat (5) @(negedge clk);
    do_write(16'd10, w1);
    buf_empty_i = 1'b1; repeat (3) @(negedge clk);
    buf_empty_i = 1'b0; tx_afull_i = 1'b1; repeat (2) @(negedge clk);
    do_write(16'd20, w2);
    tx_afull_i = 1'b0; buf_empty_i = 1'b1;
    repeat (4) @(negedge clk);
    rd64(0, v); check("R3 elapsed window", v, longint'(w2 - w1));
    check("R6 lazy (w2-w1=6)", v, 6);
    rd64(1, v); check("R4 empty in window", v, 3);
    rd64(2, v); check("R5 afull in window", v, 3);
    rd64(5, v); check("R2 bytes", v, 30);
    buf_empty_i = 1'b0;
    do_write(16'd1, w3);
    rd64(0, v); check("R3 elapsed after third write", v, longint'(w3 - w1));
    rd64(1, v); check("R4 empty committed gap", v, longint'(3 + (w3 - w2 - 1)));
    rd64(2, v); check("R5 afull unchanged", v, 3);
  endtask

  task automatic t_link();
    longint v;
    do_clear();
    link_up_i = 1'b1; repeat (5) @(negedge clk);
    tx_afull_i = 1'b1; repeat (3) @(negedge clk);
    link_up_i = 1'b0; repeat (2) @(negedge clk);
    tx_afull_i = 1'b0;
    rd64(3, v); check("R7 link up time", v, 8);
    rd64(4, v); check("R8 unblocked time", v, 5);
    rd64(0, v); check("R3 no window without writes", v, 0);
  endtask

  task automatic t_clear_write();
    int a, b, junk;
    longint v;
    wr_valid_i = 1'b1; wr_bytes_i = 16'd99; clr_i = 1'b1; junk = cyc;
    @(negedge clk);
    wr_valid_i = 1'b0; wr_bytes_i = '0; clr_i = 1'b0;
    repeat (3) @(negedge clk);
    do_write(16'd5, a);
    repeat (2) @(negedge clk);
    do_write(16'd7, b);
    rd64(0, v); check("R11 write in clear cycle does not arm", v, longint'(b - a));
    rd64(5, v); check("R11 write in clear cycle not counted", v, 12);
  endtask

  task automatic t_snapshot();
    int t;
    logic [15:0] d;
    do_clear();
    repeat (3) do_write(16'hFFFF, t);
    rd_word(5, 0, d); check("R10 low word", longint'(d), 'hFFFD);
    do_write(16'hFFFF, t);
    rd_word(5, 1, d); check("R10 word1 from snapshot", longint'(d), 2);
    rd_word(0, 2, d); check("R10 word2 other index", longint'(d), 0);
    rd_word(5, 0, d); check("R10 fresh low word", longint'(d), 'hFFFC);
    rd_word(5, 1, d); check("R10 fresh word1", longint'(d), 3);
    rd_word(6, 0, d); check("R9 index 6 zero", longint'(d), 0);
    rd_word(7, 0, d); check("R9 index 7 zero", longint'(d), 0);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    do_clear();
    wr_valid_i = 1'b1; wr_bytes_i = 16'd4; @(negedge clk);
    wr_valid_i = 1'b1; wr_bytes_i = 16'd3; rd_en_i = 1'b1; rd_addr_i = {3'd5, 2'd0};
    @(negedge clk);
    wr_valid_i = 1'b0; wr_bytes_i = '0; rd_en_i = 1'b0;
    check("R12 read sees pre-write value", longint'(rd_data_o), 4);
    rd_word(5, 0, d); check("R12 later read sees sum", longint'(d), 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_link();
    t_clear_write();
    t_snapshot();
    t_same_cycle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule